// File: doc/BRIEF.md
# Clamp-Referenced Video Gain Stage

This block scales a stream of 10-bit video samples by a programmable gain that pivots on a programmable black level. Each sample has the black level taken off, is multiplied by the gain, is rounded, and then has the black level put back. A sample that sits exactly on the black level therefore leaves the block unchanged whatever the gain. The result is saturated into the 10-bit range and leaves three clocks after the sample enters, together with a valid strobe.

A byte-wide write port loads the settings. The gain is written as two bytes. It is double-buffered and becomes pending only when the upper byte arrives. The black level is written as a 7-bit field. A sync mode can be turned on so that pending gain and black-level updates wait while the video-active input is high. They then commit on the first clock that input is low, so a setting never changes in the middle of an active line.

Top module: `clamp_agc`

## Requirements
- R1: A sample equal to the active black level comes out equal to itself, for any gain.
- R2: For sample x, black level c and gain code g, the output is floor(((x - c) * g + 256) / 512) + c, which is round-to-nearest with ties going upward.
- R3: The gain code is 12-bit unsigned with 3 integer bits [11:9] and 9 fraction bits [8:0]. A gain of 3.65 is code 0x74D, that is integer 011 and fraction 101001101 (333), and it maps a sample 100 above the black level to 365 above it.
- R4: With gain code 0x200 (1.0) the output equals the input for every sample and black level.
- R5: Write addresses: 0 is gain bits [7:0], 1 is gain bits [11:8] taken from data [3:0], 2 is the black-level field in data [6:0], 3 is the control byte with sync mode in bit 0. A write to address 1 makes {data[3:0], stored low byte} pending. A write to address 0 alone never changes the active gain.
- R6: The active black level is the 7-bit field shifted left by 3, with the low 3 bits zero.
- R7: With sync mode off, a pending gain or black level becomes active on the clock after its write. With sync mode on, it stays pending while vid_active is 1 and commits on the first clock at which vid_active is 0.
- R8: Results below 0 come out as 0 and results above 1023 come out as 1023, with no wraparound.
- R9: out_valid equals in_valid delayed by exactly 3 clocks, and out_sample belongs to the sample accepted 3 clocks earlier.
- R10: After reset, out_valid is 0, the gain is 1.0, the black level is 0 and sync mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| vid_active | input | 1 | High during active video; gates commits in sync mode |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 10 | Input sample |
| out_valid | output | 1 | Output sample valid |
| out_sample | output | 10 | Scaled and saturated output sample |

## Verification
The hardest state to reach is an update held pending in sync mode. A full two-byte gain write and a black-level write are issued while vid_active is held high, and the old settings are then shown to still be in force by pushing a probe sample through. vid_active is then pulsed low for a single clock, and a second probe shows that both settings committed at that edge. Full 1024-sample sweeps at gain settings including 0, 0.5, 1.0, 3.65 and the maximum code drive the rounding and saturation edges of the arithmetic from the sample input alone.

// File: rtl/clamp_agc_pkg.sv
package clamp_agc_pkg;
  // Write port register addresses
  typedef enum logic [1:0] {
    REG_GAIN_LO = 2'd0,
    REG_GAIN_HI = 2'd1,
    REG_BLACK   = 2'd2,
    REG_CTRL    = 2'd3
  } reg_addr_e;

  // Shared widths
  localparam int unsigned SAMPLE_W = 10;
  localparam int unsigned GAIN_W   = 12;
  localparam int unsigned GAIN_FRAC = 9;
  localparam int unsigned BLACK_FIELD_W = 7;
endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
  import clamp_agc_pkg::*;
#(
  parameter int unsigned GW  = GAIN_W,
  parameter int unsigned GFR = GAIN_FRAC,
  parameter int unsigned BFW = BLACK_FIELD_W,
  parameter int unsigned SW  = SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          vid_active,
  output logic [GW-1:0] act_gain,
  output logic [SW-1:0] act_black,
  output logic          gain_pend,
  output logic          black_pend,
  output logic          sync_mode
);
  localparam int unsigned HIW = GW - 8;
  localparam int unsigned SHIFT = SW - BFW;
  localparam logic [GW-1:0] GAIN_ONE = GW'(1) << GFR;

  logic [7:0]     lo_q, lo_d;
  logic [GW-1:0]  gval_q, gval_d;
  logic [GW-1:0]  gain_q, gain_d;
  logic [BFW-1:0] bval_q, bval_d;
  logic [BFW-1:0] black_q, black_d;
  logic           gpend_q, gpend_d;
  logic           bpend_q, bpend_d;
  logic           sync_q, sync_d;
  logic           hi_wr, blk_wr, commit_ok;

  always_comb begin
    lo_d    = lo_q;
    gval_d  = gval_q;
    gain_d  = gain_q;
    bval_d  = bval_q;
    black_d = black_q;
    gpend_d = gpend_q;
    bpend_d = bpend_q;
    sync_d  = sync_q;
    hi_wr   = wr_en && (wr_addr == REG_GAIN_HI);
    blk_wr  = wr_en && (wr_addr == REG_BLACK);
    commit_ok = !(sync_q && vid_active);
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        REG_GAIN_LO: lo_d = wr_data;
        REG_GAIN_HI: begin
          gval_d  = {wr_data[HIW-1:0], lo_q};
          gpend_d = 1'b1;
        end
        REG_BLACK: begin
          bval_d  = wr_data[BFW-1:0];
          bpend_d = 1'b1;
        end
        default: sync_d = wr_data[0];
      endcase
    end
    if (gpend_q && commit_ok) begin
      gain_d = gval_q;
      if (!hi_wr) gpend_d = 1'b0;
    end
    if (bpend_q && commit_ok) begin
      black_d = bval_q;
      if (!blk_wr) bpend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      gval_q  <= GAIN_ONE;
      gain_q  <= GAIN_ONE;
      bval_q  <= '0;
      black_q <= '0;
      gpend_q <= 1'b0;
      bpend_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      lo_q    <= lo_d;
      gval_q  <= gval_d;
      gain_q  <= gain_d;
      bval_q  <= bval_d;
      black_q <= black_d;
      gpend_q <= gpend_d;
      bpend_q <= bpend_d;
      sync_q  <= sync_d;
    end
  end

  assign act_gain   = gain_q;
  assign act_black  = {black_q, {SHIFT{1'b0}}};
  assign gain_pend  = gpend_q;
  assign black_pend = bpend_q;
  assign sync_mode  = sync_q;
endmodule

// File: rtl/agc_datapath.sv
module agc_datapath
  import clamp_agc_pkg::*;
#(
  parameter int unsigned SW  = SAMPLE_W,
  parameter int unsigned GW  = GAIN_W,
  parameter int unsigned GFR = GAIN_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  input  logic [GW-1:0] gain,
  input  logic [SW-1:0] black,
  output logic          out_valid,
  output logic [SW-1:0] out_sample
);
  localparam int unsigned DW = SW + 1;           // signed difference
  localparam int unsigned PW = DW + GW + 1;      // signed product
  localparam int unsigned RW = PW - GFR;         // after scaling
  localparam int unsigned AW = RW + 1;           // after black add
  localparam logic signed [PW-1:0] HALF = PW'(1) << (GFR - 1);
  localparam logic signed [AW-1:0] MAXV = AW'((1 << SW) - 1);

  // Stage 1: difference from black level
  logic                 v1_q;
  logic signed [DW-1:0] d1_q, d1_d;
  logic [GW-1:0]        g1_q;
  logic [SW-1:0]        c1_q;
  // Stage 2: scaled and rounded difference
  logic                 v2_q;
  logic signed [RW-1:0] r2_q, r2_d;
  logic [SW-1:0]        c2_q;
  // Stage 3: restored and saturated result
  logic                 v3_q;
  logic [SW-1:0]        o3_q, o3_d;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] sum;

  always_comb begin
    d1_d = $signed({1'b0, in_sample}) - $signed({1'b0, black});
    prod = PW'(d1_q) * $signed({1'b0, g1_q});
    r2_d = RW'((prod + HALF) >>> GFR);
    sum  = AW'(r2_q) + $signed({{(AW-SW){1'b0}}, c2_q});
    if (sum < 0)          o3_d = '0;
    else if (sum > MAXV)  o3_d = '1;
    else                  o3_d = sum[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      v3_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
      v3_q <= v2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= '0;
      g1_q <= '0;
      c1_q <= '0;
      r2_q <= '0;
      c2_q <= '0;
      o3_q <= '0;
    end else begin
      if (in_valid) begin
        d1_q <= d1_d;
        g1_q <= gain;
        c1_q <= black;
      end
      if (v1_q) begin
        r2_q <= r2_d;
        c2_q <= c1_q;
      end
      if (v2_q) begin
        o3_q <= o3_d;
      end
    end
  end

  assign out_valid  = v3_q;
  assign out_sample = o3_q;
endmodule

// File: rtl/clamp_agc.sv
module clamp_agc
  import clamp_agc_pkg::*;
#(
  parameter int unsigned SW  = SAMPLE_W,
  parameter int unsigned GW  = GAIN_W,
  parameter int unsigned GFR = GAIN_FRAC,
  parameter int unsigned BFW = BLACK_FIELD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          vid_active,
  input  logic          in_valid,
  input  logic [SW-1:0] in_sample,
  output logic          out_valid,
  output logic [SW-1:0] out_sample
);
  logic [GW-1:0] act_gain;
  logic [SW-1:0] act_black;
  logic          gain_pend;
  logic          black_pend;
  logic          sync_mode;

  agc_cfg_regs #(.GW(GW), .GFR(GFR), .BFW(BFW), .SW(SW)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .vid_active (vid_active),
    .act_gain   (act_gain),
    .act_black  (act_black),
    .gain_pend  (gain_pend),
    .black_pend (black_pend),
    .sync_mode  (sync_mode)
  );

  agc_datapath #(.SW(SW), .GW(GW), .GFR(GFR)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .gain       (act_gain),
    .black      (act_black),
    .out_valid  (out_valid),
    .out_sample (out_sample)
  );
endmodule

// File: rtl/clamp_agc_chk.sv
module clamp_agc_chk #(
  parameter int unsigned SW = 10,
  parameter int unsigned GW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          vid_active,
  input logic          in_valid,
  input logic [SW-1:0] in_sample,
  input logic          out_valid,
  input logic [SW-1:0] out_sample,
  input logic [GW-1:0] act_gain,
  input logic [SW-1:0] act_black,
  input logic          gain_pend,
  input logic          sync_mode
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (out_valid == $past(in_valid, 3)));  // R9

  AST_BLACK_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sample == act_black) |-> ##3 (out_valid && out_sample == $past(in_sample, 3)));  // R1

  AST_LO_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && !gain_pend) |=> $stable(act_gain));  // R5

  AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && vid_active) |=> ($stable(act_gain) && $stable(act_black)));  // R7

  AST_PEND_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_pend && !(sync_mode && vid_active) && !(wr_en && wr_addr == 2'd1)) |=> !gain_pend);  // R7
endmodule

bind clamp_agc clamp_agc_chk #(.SW(SW), .GW(GW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .vid_active (vid_active),
  .in_valid   (in_valid),
  .in_sample  (in_sample),
  .out_valid  (out_valid),
  .out_sample (out_sample),
  .act_gain   (act_gain),
  .act_black  (act_black),
  .gain_pend  (gain_pend),
  .sync_mode  (sync_mode)
);

// File: tb/clamp_agc_tb_top.sv
module clamp_agc_tb_top;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       vid_active;
  logic       in_valid;
  logic [9:0] in_sample;
  logic       out_valid;
  logic [9:0] out_sample;

  int checks;
  int failures;
  bit done;
  int exp_arr [1024];

  clamp_agc dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vid_active(vid_active), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int model(int x, int g, int c);
    int p;
    int q;
    int r;
    p = (x - c) * g + 256;
    if (p >= 0) q = p / 512;
    else        q = -((-p + 511) / 512);
    r = q + c;
    if (r < 0)    r = 0;
    if (r > 1023) r = 1023;
    return r;
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr[1:0]; wr_data = data[7:0];
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_gain(int g);
    wr(0, g & 255);
    wr(1, g >> 8);
  endtask

  // One isolated sample; checks valid timing and returns the output value
  task automatic probe(string req, int x, output int res);
    @(negedge clk);
    in_valid = 1'b1; in_sample = x[9:0];
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R9", int'(out_valid), 0);
    @(negedge clk);
    check("R9", int'(out_valid), 1);
    res = int'(out_sample);
    @(negedge clk);
    check("R9", int'(out_valid), 0);
  endtask

  task automatic sweep(string req, int g, int field);
    int c;
    c = field * 8;
    set_gain(g);
    wr(2, field);
    for (int i = 0; i < 1024; i++) exp_arr[i] = model(i, g, c);
    for (int i = 0; i < 1027; i++) begin
      @(negedge clk);
      if (i >= 3) begin
        check("R9", int'(out_valid), 1);
        check(req, int'(out_sample), exp_arr[i-3]);
      end
      if (i < 1024) begin
        in_valid = 1'b1; in_sample = i[9:0];
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    vid_active = 1'b0; in_valid = 1'b0; in_sample = '0;
    repeat (3) @(negedge clk);
    check("R10", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", int'(out_valid), 0);
    probe("R10", 777, r);
    check("R10", r, 777);

    // R4 identity at gain 1.0 with a nonzero black level
    sweep("R4", 512, 50);
    // R3 gain 3.65 encoding: lo 0x4D, hi 0x07
    sweep("R2", 1869, 16);
    probe("R3", 128 + 100, r);
    check("R3", r, 128 + 365);
    probe("R1", 128, r);
    check("R1", r, 128);
    // R8 saturation at both ends
    sweep("R8", 4095, 127);
    probe("R8", 0, r);
    check("R8", r, 0);
    probe("R8", 1023, r);
    check("R8", r, 1023);
    // R6 black level = field << 3, gain 0 gives the black level
    sweep("R6", 0, 64);
    probe("R6", 3, r);
    check("R6", r, 512);
    // R2 rounding with gain 0.5 (ties upward)
    sweep("R2", 256, 5);
    probe("R2", 41, r);
    check("R2", r, 41);
    probe("R2", 39, r);
    check("R2", r, 40);

    // R5 low-byte write alone keeps active gain (0.5, black 40)
    wr(0, 0);
    probe("R5", 140, r);
    check("R5", r, 90);
    wr(1, 4);
    probe("R5", 140, r);
    check("R5", r, 240);

    // R7 sync mode holds updates during active video
    wr(3, 1);
    vid_active = 1'b1;
    set_gain(512);
    wr(2, 0);
    probe("R7", 140, r);
    check("R7", r, 240);
    @(negedge clk);
    vid_active = 1'b0;
    @(negedge clk);
    vid_active = 1'b1;
    probe("R7", 140, r);
    check("R7", r, 140);
    // R7 sync mode off: immediate commit
    wr(3, 0);
    set_gain(1024);
    probe("R7", 140, r);
    check("R7", r, 280);
    vid_active = 1'b0;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule